// File: doc/BRIEF.md
# Six-Pin GPIO Port with Peripheral Override

This block owns the direction and output source of six general-purpose pins. Software reaches it through a small register window: a read-only status word that reports the synchronized pin levels, a direction word, and a port data word. Several peripherals can take a pin away from software control. A PWM unit with six channels does this, as do an I2C unit and a serial transmitter and receiver. For each pin the block settles on one owner by a fixed priority: PWM first, then I2C, then serial, then the direction word.

PWM channel 5 has an emergency-shutdown mode. When that mode is on and the channel is enabled, pin 5 becomes an input so that a fault level can reach the PWM unit. The I2C pins behave as open-drain lines: the pad driver is enabled only while the I2C unit pulls low. Every pin level passes through a two-flop synchronizer before it reaches software or any peripheral.

Top module: `gpio_override_port`

## Requirements
- R1: After reset the direction and data words read 0 and every `pin_oe` bit is 0.
- R2: Address 0 returns the pin levels in bits 5:0, two clock edges after they are presented on `pin_in`. Bits 7:6 read 0. Writes to address 0 change nothing.
- R3: Address 1 (direction) and address 2 (data) hold bits 5:0 of any write, and bits 7:6 read back as 0. Address 3 reads 0. A write takes effect at the clock edge that samples it.
- R4: A pin that no peripheral owns has `pin_oe[n]` = direction bit n. It drives data bit n when that direction bit is 1.
- R5: When `pwm_en[n]` is 1, pin n is an output that carries `pwm_val[n]`, whatever the direction bit and the other peripherals are doing.
- R6: When `pwm_en[5]` and `pwm_sd_en` are both 1, pin 5 is an input.
- R7: When `i2c_en` is 1, each of pin 5 (clock) and pin 4 (data) whose PWM channel is off becomes open-drain. Its `pin_oe` equals `i2c_scl_low` or `i2c_sda_low` respectively, and its `pin_out` is 0.
- R8: When neither PWM nor I2C owns the pin, `ser_tx_en` makes pin 0 an output that carries `ser_tx_d`, and `ser_rx_en` makes pin 2 an input.
- R9: `pin_out[n]` is 0 whenever `pin_oe[n]` is 0.
- R10: `i2c_scl_in` and `pwm_fault_in` give the synchronized level of pin 5, `i2c_sda_in` gives that of pin 4, and `ser_rx_in` gives that of pin 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 6 | Pad input levels |
| pin_oe | output | 6 | Pad output enables |
| pin_out | output | 6 | Pad output values |
| pwm_en | input | 6 | PWM channel enables |
| pwm_val | input | 6 | PWM channel outputs |
| pwm_sd_en | input | 1 | Shutdown mode on channel 5 |
| pwm_fault_in | output | 1 | Synchronized pin 5 level for the shutdown input |
| i2c_en | input | 1 | I2C unit enable |
| i2c_scl_low | input | 1 | I2C pulls the clock line low |
| i2c_sda_low | input | 1 | I2C pulls the data line low |
| i2c_scl_in | output | 1 | Synchronized clock line level |
| i2c_sda_in | output | 1 | Synchronized data line level |
| ser_tx_en | input | 1 | Serial transmitter enable |
| ser_tx_d | input | 1 | Serial transmit bit |
| ser_rx_en | input | 1 | Serial receiver enable |
| ser_rx_in | output | 1 | Synchronized receive level |

## Verification
The pad controls `pin_oe` and `pin_out` are combinational. They are due in the same cycle as a change of a peripheral enable, and one edge after a register write. The bench therefore writes, waits for the next falling edge and then applies and checks each vector after a short settle delay. Pin levels cost two edges. The bench checks the status word and the peripheral returns after one edge, expecting the old value, and again after the second edge, expecting the new one. Register reads are combinational, so each is checked just after the address is set, away from any edge.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;
  localparam int NPINS  = 6;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  // pins whose role is fixed by the peripheral wiring
  localparam int SCL_IDX = 5;
  localparam int SDA_IDX = 4;
  localparam int TX_IDX  = 0;
  localparam int RX_IDX  = 2;
  localparam int SD_IDX  = 5;

  localparam logic [ADDR_W-1:0] A_STS = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR = 2'd1;
  localparam logic [ADDR_W-1:0] A_DAT = 2'd2;

  typedef enum logic [2:0] {
    OWN_GPIO,
    OWN_PWM,
    OWN_PWM_SD,
    OWN_I2C,
    OWN_TX,
    OWN_RX
  } owner_e;

  // priority: PWM > I2C > serial > direction register
  function automatic owner_e pick_owner(input int idx, input logic pwm_on,
                                        input logic sd_on, input logic i2c_on,
                                        input logic tx_on, input logic rx_on);
    if (pwm_on) return (idx == SD_IDX && sd_on) ? OWN_PWM_SD : OWN_PWM;
    if (i2c_on && (idx == SCL_IDX || idx == SDA_IDX)) return OWN_I2C;
    if (tx_on && idx == TX_IDX) return OWN_TX;
    if (rx_on && idx == RX_IDX) return OWN_RX;
    return OWN_GPIO;
  endfunction
endpackage

// File: rtl/gpio_ovr_sync.sv
`timescale 1ns/1ps
module gpio_ovr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
`timescale 1ns/1ps
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NP = NPINS,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NP-1:0] pin_sts,
  output logic [NP-1:0] dir_q,
  output logic [NP-1:0] dat_q
);
  localparam int PAD = DW - NP;

  logic wr_dir, wr_dat;
  logic unused_wbits;

  assign wr_dir = wr && (addr == A_DIR);
  assign wr_dat = wr && (addr == A_DAT);
  assign unused_wbits = ^wdata[DW-1:NP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata[NP-1:0];
      if (wr_dat) dat_q <= wdata[NP-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      A_STS:   rdata = {{PAD{1'b0}}, pin_sts};
      A_DIR:   rdata = {{PAD{1'b0}}, dir_q};
      A_DAT:   rdata = {{PAD{1'b0}}, dat_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_mux.sv
`timescale 1ns/1ps
module gpio_ovr_mux
  import gpio_ovr_pkg::*;
#(
  parameter int NP = NPINS
) (
  input  logic                dir_q_i,
  input  logic [NP-1:0]       dir_q,
  input  logic [NP-1:0]       dat_q,
  input  logic [NP-1:0]       pwm_en,
  input  logic [NP-1:0]       pwm_val,
  input  logic                pwm_sd_en,
  input  logic                i2c_en,
  input  logic                i2c_scl_low,
  input  logic                i2c_sda_low,
  input  logic                ser_tx_en,
  input  logic                ser_tx_d,
  input  logic                ser_rx_en,
  output owner_e [NP-1:0]     owner,
  output logic [NP-1:0]       pin_oe,
  output logic [NP-1:0]       pin_out
);
  logic unused_tie;
  assign unused_tie = dir_q_i;

  for (genvar i = 0; i < NP; i++) begin : g_pin
    logic od_low;
    logic tx_bit;

    if (i == SCL_IDX) begin : g_scl
      assign od_low = i2c_scl_low;
    end else if (i == SDA_IDX) begin : g_sda
      assign od_low = i2c_sda_low;
    end else begin : g_nod
      assign od_low = 1'b0;
    end

    if (i == TX_IDX) begin : g_tx
      assign tx_bit = ser_tx_d;
    end else begin : g_ntx
      assign tx_bit = 1'b0;
    end

    always_comb begin
      owner[i] = pick_owner(i, pwm_en[i], pwm_sd_en, i2c_en, ser_tx_en, ser_rx_en);
      unique case (owner[i])
        OWN_PWM:    begin pin_oe[i] = 1'b1;   pin_out[i] = pwm_val[i]; end
        OWN_PWM_SD: begin pin_oe[i] = 1'b0;   pin_out[i] = 1'b0;       end
        OWN_I2C:    begin pin_oe[i] = od_low; pin_out[i] = 1'b0;       end
        OWN_TX:     begin pin_oe[i] = 1'b1;   pin_out[i] = tx_bit;     end
        OWN_RX:     begin pin_oe[i] = 1'b0;   pin_out[i] = 1'b0;       end
        default:    begin pin_oe[i] = dir_q[i]; pin_out[i] = dir_q[i] & dat_q[i]; end
      endcase
    end
  end
endmodule

// File: rtl/gpio_override_port.sv
`timescale 1ns/1ps
module gpio_override_port
  import gpio_ovr_pkg::*;
#(
  parameter int NP          = NPINS,
  parameter int DW          = DATA_W,
  parameter int AW          = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_out,
  input  logic [NP-1:0] pwm_en,
  input  logic [NP-1:0] pwm_val,
  input  logic          pwm_sd_en,
  output logic          pwm_fault_in,
  input  logic          i2c_en,
  input  logic          i2c_scl_low,
  input  logic          i2c_sda_low,
  output logic          i2c_scl_in,
  output logic          i2c_sda_in,
  input  logic          ser_tx_en,
  input  logic          ser_tx_d,
  input  logic          ser_rx_en,
  output logic          ser_rx_in
);
  // named internal wires, visible to the bound checker
  logic [NP-1:0]   pin_sync;
  logic [NP-1:0]   dir_q;
  logic [NP-1:0]   dat_q;
  owner_e [NP-1:0] owner;

  gpio_ovr_sync #(.WIDTH(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  gpio_ovr_regs #(.NP(NP), .DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .pin_sts(pin_sync),
    .dir_q  (dir_q),
    .dat_q  (dat_q)
  );

  gpio_ovr_mux #(.NP(NP)) u_mux (
    .dir_q_i    (1'b0),
    .dir_q      (dir_q),
    .dat_q      (dat_q),
    .pwm_en     (pwm_en),
    .pwm_val    (pwm_val),
    .pwm_sd_en  (pwm_sd_en),
    .i2c_en     (i2c_en),
    .i2c_scl_low(i2c_scl_low),
    .i2c_sda_low(i2c_sda_low),
    .ser_tx_en  (ser_tx_en),
    .ser_tx_d   (ser_tx_d),
    .ser_rx_en  (ser_rx_en),
    .owner      (owner),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
  );

  assign i2c_scl_in   = pin_sync[SCL_IDX];
  assign i2c_sda_in   = pin_sync[SDA_IDX];
  assign pwm_fault_in = pin_sync[SD_IDX];
  assign ser_rx_in    = pin_sync[RX_IDX];
endmodule

// File: rtl/gpio_ovr_chk.sv
`timescale 1ns/1ps
module gpio_ovr_chk
  import gpio_ovr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [5:0]    pin_in,
  input logic [5:0]    pin_sync,
  input logic [5:0]    dir_q,
  input logic [5:0]    pin_oe,
  input logic [5:0]    pin_out,
  input logic [5:0]    pwm_en,
  input logic [5:0]    pwm_val,
  input logic          pwm_sd_en,
  input logic          i2c_en,
  input logic          i2c_scl_low,
  input logic          ser_rx_in
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  sts_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIR) |=> (dir_q == $past(reg_wdata[5:0])));

  // R5
  pwm_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en[0] |-> (pin_oe[0] && pin_out[0] == pwm_val[0]));

  // R6
  shutdown_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en[5] && pwm_sd_en) |-> !pin_oe[5]);

  // R7
  scl_open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_en && !pwm_en[5]) |-> (pin_oe[5] == i2c_scl_low && !pin_out[5]));

  // R9
  quiet_when_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == 6'd0);

  // R10
  rx_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (ser_rx_in == $past(pin_in[2], 2)));
endmodule

bind gpio_override_port gpio_ovr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .pin_in     (pin_in),
  .pin_sync   (pin_sync),
  .dir_q      (dir_q),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .pwm_en     (pwm_en),
  .pwm_val    (pwm_val),
  .pwm_sd_en  (pwm_sd_en),
  .i2c_en     (i2c_en),
  .i2c_scl_low(i2c_scl_low),
  .ser_rx_in  (ser_rx_in)
);

// File: tb/sim_gpio_override_port.sv
`timescale 1ns/1ps
module sim_gpio_override_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_oe, pin_out;
  logic [5:0] pwm_en = '0, pwm_val = '0;
  logic pwm_sd_en = 1'b0, pwm_fault_in;
  logic i2c_en = 1'b0, i2c_scl_low = 1'b0, i2c_sda_low = 1'b0;
  logic i2c_scl_in, i2c_sda_in;
  logic ser_tx_en = 1'b0, ser_tx_d = 1'b0, ser_rx_en = 1'b0, ser_rx_in;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_override_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pwm_en(pwm_en), .pwm_val(pwm_val),
    .pwm_sd_en(pwm_sd_en), .pwm_fault_in(pwm_fault_in), .i2c_en(i2c_en),
    .i2c_scl_low(i2c_scl_low), .i2c_sda_low(i2c_sda_low),
    .i2c_scl_in(i2c_scl_in), .i2c_sda_in(i2c_sda_in), .ser_tx_en(ser_tx_en),
    .ser_tx_d(ser_tx_d), .ser_rx_en(ser_rx_en), .ser_rx_in(ser_rx_in)
  );

  typedef struct packed {
    logic [5:0] dir;
    logic [5:0] dat;
    logic [5:0] pen;
    logic [5:0] pval;
    logic       sd;
    logic       i2c;
    logic       scl;
    logic       sda;
    logic       tx;
    logic       txd;
    logic       rx;
    logic [5:0] eoe;
    logic [5:0] eout;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // dir    dat    pen    pval   sd  i2c scl sda tx  txd rx   eoe    eout
    '{6'h3F, 6'h2A, 6'h00, 6'h00, 0,0,0,0,0,0,0, 6'h3F, 6'h2A}, // R4 all out
    '{6'h00, 6'h3F, 6'h00, 6'h00, 0,0,0,0,0,0,0, 6'h00, 6'h00}, // R4 R9 all in
    '{6'h00, 6'h15, 6'h3F, 6'h33, 0,0,0,0,0,0,0, 6'h3F, 6'h33}, // R5
    '{6'h00, 6'h15, 6'h3F, 6'h33, 1,0,0,0,0,0,0, 6'h1F, 6'h13}, // R6
    '{6'h3F, 6'h3F, 6'h00, 6'h00, 0,1,1,0,0,0,0, 6'h2F, 6'h0F}, // R7
    '{6'h00, 6'h00, 6'h20, 6'h20, 0,1,1,1,0,0,0, 6'h30, 6'h20}, // R5 over R7
    '{6'h3F, 6'h3F, 6'h00, 6'h00, 0,0,0,0,1,0,1, 6'h3B, 6'h3A}, // R8
    '{6'h00, 6'h00, 6'h01, 6'h00, 0,0,0,0,1,1,0, 6'h01, 6'h00}, // R5 over R8
    '{6'h00, 6'h00, 6'h00, 6'h00, 0,1,0,1,1,1,1, 6'h11, 6'h01}  // R7 R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic idle_periph();
    pwm_en = '0; pwm_val = '0; pwm_sd_en = 0; i2c_en = 0; i2c_scl_low = 0;
    i2c_sda_low = 0; ser_tx_en = 0; ser_tx_d = 0; ser_rx_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held
    rd_chk(2'd1, 8'h00, "R1 dir");
    rd_chk(2'd2, 8'h00, "R1 dat");
    check("R1 oe", {2'b0, pin_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int k = 0; k < NV; k++) begin
      idle_periph();
      wr_reg(2'd1, {2'b0, VECS[k].dir});
      wr_reg(2'd2, {2'b0, VECS[k].dat});
      pwm_en = VECS[k].pen; pwm_val = VECS[k].pval; pwm_sd_en = VECS[k].sd;
      i2c_en = VECS[k].i2c; i2c_scl_low = VECS[k].scl; i2c_sda_low = VECS[k].sda;
      ser_tx_en = VECS[k].tx; ser_tx_d = VECS[k].txd; ser_rx_en = VECS[k].rx;
      #1;
      check($sformatf("R4-table oe vec%0d", k), {2'b0, pin_oe}, {2'b0, VECS[k].eoe});
      check($sformatf("R9-table out vec%0d", k), {2'b0, pin_out}, {2'b0, VECS[k].eout});
    end
    idle_periph();

    // R3 register width and unused address
    wr_reg(2'd1, 8'hFF);
    rd_chk(2'd1, 8'h3F, "R3 dir upper bits");
    wr_reg(2'd2, 8'hD5);
    rd_chk(2'd2, 8'h15, "R3 dat");
    rd_chk(2'd3, 8'h00, "R3 addr3");
    // R4 GPIO output follows data word after the write edge
    #1;
    check("R4 after write", {2'b0, pin_out}, 8'h15);

    // R2 status latency and read-only behaviour
    @(negedge clk);
    pin_in = 6'h2A;
    @(posedge clk); @(negedge clk);
    rd_chk(2'd0, 8'h00, "R2 one edge old");
    check("R10 rx one edge old", {7'b0, ser_rx_in}, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_chk(2'd0, 8'h2A, "R2 two edges new");
    check("R10 scl", {7'b0, i2c_scl_in}, 8'h01);
    check("R10 sda", {7'b0, i2c_sda_in}, 8'h00);
    check("R10 rx", {7'b0, ser_rx_in}, 8'h00);
    check("R10 fault", {7'b0, pwm_fault_in}, 8'h01);
    wr_reg(2'd0, 8'hFF);
    rd_chk(2'd0, 8'h2A, "R2 write ignored sts");
    rd_chk(2'd1, 8'h3F, "R2 write ignored dir");
    rd_chk(2'd2, 8'h15, "R2 write ignored dat");

    @(negedge clk);
    pin_in = 6'h15;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_chk(2'd0, 8'h15, "R2 second pattern");
    check("R10 rx high", {7'b0, ser_rx_in}, 8'h01);
    check("R10 sda high", {7'b0, i2c_sda_in}, 8'h01);

    // R6 shutdown without channel enable has no effect on pin 5
    pwm_sd_en = 1'b1;
    #1;
    check("R6 sd alone", {7'b0, pin_oe[5]}, 8'h01);
    pwm_en = 6'h20; pwm_val = 6'h20;
    #1;
    check("R6 sd with channel", {7'b0, pin_oe[5]}, 8'h00);
    idle_periph();

    // R1 reset again clears the words
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_chk(2'd1, 8'h00, "R1 re-reset dir");
    rd_chk(2'd0, 8'h00, "R1 re-reset sts");
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule